// File: doc/BRIEF.md
# Low-Order Path V5 Overhead Generator

This block sits in the transmit path of a low-order tributary. It passes the tributary byte stream through with one cycle of latency and replaces the byte at each multiframe start with a freshly built V5 path overhead byte. The V5 byte carries a two-bit interleaved parity (BIP-2) that covers every byte sent in the previous multiframe, including that multiframe's own V5. It also carries the remote error and remote defect indications, a remote failure bit and a three-bit signal label. The block also drives the three extended remote defect bits that belong in the K4 byte.

Each of the two remote indications has its own source. A force control drives it to one. Otherwise, with automatic update enabled, it follows the receive-side status. With automatic update disabled, it takes a value supplied by the processor. Forcing the defect indication also drives the K4 field to all ones. A parity-inversion control sends both BIP-2 bits complemented, so that downstream checkers can be tested. All controls and receive status are sampled only in the cycle that carries the multiframe marker. Each V5 byte is therefore built from one consistent set of settings.

Top module: `v5_gen`

## Requirements
- R1: After reset, out_valid is 0, v5_last is 8'h00 and k4_erdi is 3'b000, and the parity accumulator is clear, so the first V5 carries BIP-2 = 2'b00 unless inversion is requested.
- R2: A valid input byte without the marker appears unchanged on out_byte one cycle later, with out_valid = 1 and out_mf_start = 0. A cycle with in_valid = 0 gives out_valid = 0 one cycle later.
- R3: A valid byte with in_mf_start = 1 is replaced one cycle later by the V5 byte. Its layout is: [7:6] BIP-2, [5] REI, [4] RFI (= rfi_in), [3:1] signal label (= label_in), [0] RDI. The same value appears on v5_last, and out_mf_start = 1.
- R4: V5 bit [7] is the XOR of bits 7, 5, 3 and 1 of every byte sent in the previous multiframe, that multiframe's V5 included. Bit [6] is the XOR of bits 6, 4, 2 and 0 of the same bytes.
- R5: With rdi_force = 0 and rdi_auto_en = 1, RDI equals rx_defect.
- R6: With rdi_force = 0 and rdi_auto_en = 0, RDI equals rdi_sw.
- R7: With rdi_force = 1, RDI is 1 and k4_erdi is 3'b111, whatever the other RDI inputs are.
- R8: With rdi_force = 0, k4_erdi equals erdi_sw.
- R9: With rei_force = 0 and rei_auto_en = 1, REI is 1 exactly when rx_bip_errs is nonzero.
- R10: With rei_force = 0 and rei_auto_en = 0, REI equals rei_sw.
- R11: With rei_force = 1, REI is 1.
- R12: With bip_inv = 1, both BIP-2 bits are sent as the complement of the values that R4 gives.
- R13: All controls and receive status take effect only in a marker cycle. v5_last and k4_erdi do not change in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_byte | input | 8 | Tributary byte to transmit |
| in_mf_start | input | 1 | This byte is the V5 position (first byte of a multiframe) |
| rx_defect | input | 1 | Receive-side defect status for automatic RDI |
| rx_bip_errs | input | ERR_W | Parity errors counted by the receiver over its last multiframe |
| rdi_auto_en | input | 1 | RDI follows rx_defect when 1 |
| rdi_force | input | 1 | Drive RDI to 1 and K4 extended bits to 111 |
| rdi_sw | input | 1 | Processor RDI value when automatic update is off |
| rei_auto_en | input | 1 | REI follows rx_bip_errs when 1 |
| rei_force | input | 1 | Drive REI to 1 |
| rei_sw | input | 1 | Processor REI value when automatic update is off |
| bip_inv | input | 1 | Complement both BIP-2 bits |
| rfi_in | input | 1 | Remote failure bit for V5 |
| label_in | input | 3 | Signal label for V5 |
| erdi_sw | input | 3 | K4 extended defect bits when RDI is not forced |
| out_valid | output | 1 | Output byte is valid |
| out_byte | output | 8 | Transmitted byte with V5 inserted |
| out_mf_start | output | 1 | Output byte is a V5 byte |
| v5_last | output | 8 | Most recent V5 byte built |
| k4_erdi | output | 3 | K4 extended remote defect bits |

## Verification
The parity is driven with random byte values over multiframes of random length, with idle gaps inside them. Because the inversion setting changes from one multiframe to the next, the sent V5 value feeds back into the following parity. Separate checks of the odd and even bit groups show that the bits are split correctly and do not merely count bytes. Each marker cycle uses a random mix of force, automatic and processor settings. The bench checks each field against the source that should win, so a wrong priority between force, automatic and manual shows up as a mismatch in one field. Controls and status are also toggled between markers. Stable V5 and K4 outputs then show that only marker-cycle values are taken. Directed cases cover the first multiframe after reset, an error count at its largest value and at zero, and the defect force with all other inputs opposed.

// File: rtl/v5_gen_pkg.sv
package v5_gen_pkg;

  // V5 field layout, most significant bit first
  typedef struct packed {
    logic [1:0] bip;
    logic       rei;
    logic       rfi;
    logic [2:0] sig_label;
    logic       rdi;
  } v5_t;

  localparam int NFLAG    = 2;
  localparam int FLAG_RDI = 0;
  localparam int FLAG_REI = 1;

  // parity contribution of one byte: {odd-numbered bits, even-numbered bits}
  function automatic logic [1:0] bip_fold(input logic [7:0] b);
    return {b[7] ^ b[5] ^ b[3] ^ b[1], b[6] ^ b[4] ^ b[2] ^ b[0]};
  endfunction

  function automatic logic [7:0] v5_pack(input logic [1:0] bip, input logic rei,
                                         input logic rfi, input logic [2:0] lbl,
                                         input logic rdi);
    v5_t v;
    v.bip       = bip;
    v.rei       = rei;
    v.rfi       = rfi;
    v.sig_label = lbl;
    v.rdi       = rdi;
    return v;
  endfunction

endpackage

// File: rtl/v5_flag_sel.sv
module v5_flag_sel (
  input  logic force_i,
  input  logic auto_en,
  input  logic hw_val,
  input  logic sw_val,
  output logic flag
);
  // force wins, then hardware status, then processor value
  always_comb begin
    if (force_i)      flag = 1'b1;
    else if (auto_en) flag = hw_val;
    else              flag = sw_val;
  end
endmodule

// File: rtl/v5_bip_acc.sv
module v5_bip_acc
  import v5_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       restart,
  input  logic [7:0] byte_sent,
  output logic [1:0] acc_q
);
  logic [1:0] contrib;
  assign contrib = bip_fold(byte_sent);

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= 2'b00;
    else if (restart) acc_q <= contrib;          // new multiframe starts with its V5
    else if (step)    acc_q <= acc_q ^ contrib;
  end

  // R4: outside valid cycles the running parity holds
  a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(acc_q));
endmodule

// File: rtl/v5_gen.sv
module v5_gen
  import v5_gen_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_mf_start,
  input  logic             rx_defect,
  input  logic [ERR_W-1:0] rx_bip_errs,
  input  logic             rdi_auto_en,
  input  logic             rdi_force,
  input  logic             rdi_sw,
  input  logic             rei_auto_en,
  input  logic             rei_force,
  input  logic             rei_sw,
  input  logic             bip_inv,
  input  logic             rfi_in,
  input  logic [2:0]       label_in,
  input  logic [2:0]       erdi_sw,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_mf_start,
  output logic [7:0]       v5_last,
  output logic [2:0]       k4_erdi
);
  localparam logic [2:0] ERDI_FORCED = 3'b111;

  logic             boundary;
  logic [NFLAG-1:0] flag_force, flag_auto, flag_hw, flag_sw, flag_out;
  logic [1:0]       acc_q;
  logic [1:0]       bip_now;
  logic [7:0]       v5_new;
  logic [7:0]       sent_byte;
  logic [2:0]       erdi_new;

  assign boundary = in_valid & in_mf_start;

  assign flag_force[FLAG_RDI] = rdi_force;
  assign flag_auto [FLAG_RDI] = rdi_auto_en;
  assign flag_hw   [FLAG_RDI] = rx_defect;
  assign flag_sw   [FLAG_RDI] = rdi_sw;
  assign flag_force[FLAG_REI] = rei_force;
  assign flag_auto [FLAG_REI] = rei_auto_en;
  assign flag_hw   [FLAG_REI] = |rx_bip_errs;
  assign flag_sw   [FLAG_REI] = rei_sw;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    v5_flag_sel u_sel (
      .force_i (flag_force[g]),
      .auto_en (flag_auto[g]),
      .hw_val  (flag_hw[g]),
      .sw_val  (flag_sw[g]),
      .flag    (flag_out[g])
    );
  end

  assign bip_now   = acc_q ^ {2{bip_inv}};
  assign v5_new    = v5_pack(bip_now, flag_out[FLAG_REI], rfi_in, label_in,
                             flag_out[FLAG_RDI]);
  assign sent_byte = in_mf_start ? v5_new : in_byte;
  assign erdi_new  = rdi_force ? ERDI_FORCED : erdi_sw;

  v5_bip_acc u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (in_valid),
    .restart   (boundary),
    .byte_sent (sent_byte),
    .acc_q     (acc_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_byte     <= 8'h00;
      out_mf_start <= 1'b0;
      v5_last      <= 8'h00;
      k4_erdi      <= 3'b000;
    end else begin
      out_valid    <= in_valid;
      out_mf_start <= boundary;
      if (in_valid) out_byte <= sent_byte;
      if (boundary) begin
        v5_last <= v5_new;
        k4_erdi <= erdi_new;
      end
    end
  end

  // R2: payload bytes pass unchanged after one cycle
  a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mf_start) |=> (out_valid && !out_mf_start && out_byte == $past(in_byte)));
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3: the V5 slot on the stream matches the recorded V5
  a_r3_slot: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (out_mf_start && out_byte == v5_last));
  // R5: automatic RDI follows the defect status
  a_r5_rdi_auto: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !rdi_force && rdi_auto_en) |=> v5_last[0] == $past(rx_defect));
  // R7: forced RDI with all-ones extended bits
  a_r7_rdi_force: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && rdi_force) |=> (v5_last[0] && k4_erdi == 3'b111));
  // R11: forced REI
  a_r11_rei_force: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && rei_force) |=> v5_last[5]);
  // R12: parity bits relative to the accumulator and the inversion control
  a_r12_invert: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> v5_last[7:6] == ($past(acc_q) ^ {2{$past(bip_inv)}}));
  // R13: overhead outputs change only at a marker
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(v5_last) && $stable(k4_erdi)));
endmodule

// File: tb/tb_v5_gen.sv
`timescale 1ns/1ps
module tb_v5_gen;
  localparam int ERR_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_mf_start;
  logic [7:0] in_byte;
  logic rx_defect;
  logic [ERR_W-1:0] rx_bip_errs;
  logic rdi_auto_en, rdi_force, rdi_sw, rei_auto_en, rei_force, rei_sw, bip_inv, rfi_in;
  logic [2:0] label_in, erdi_sw;
  logic out_valid, out_mf_start;
  logic [7:0] out_byte, v5_last;
  logic [2:0] k4_erdi;

  always #2.5 clk = ~clk;

  v5_gen #(.ERR_W(ERR_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_mf_start(in_mf_start), .rx_defect(rx_defect), .rx_bip_errs(rx_bip_errs),
    .rdi_auto_en(rdi_auto_en), .rdi_force(rdi_force), .rdi_sw(rdi_sw),
    .rei_auto_en(rei_auto_en), .rei_force(rei_force), .rei_sw(rei_sw),
    .bip_inv(bip_inv), .rfi_in(rfi_in), .label_in(label_in), .erdi_sw(erdi_sw),
    .out_valid(out_valid), .out_byte(out_byte), .out_mf_start(out_mf_start),
    .v5_last(v5_last), .k4_erdi(k4_erdi)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0] m_acc;
  logic [7:0] m_v5;
  logic [2:0] m_k4;

  // parity by bit number counted from the MSB: odd numbers sit at odd indices
  function automatic logic [1:0] par_of(input logic [7:0] b);
    logic po = 1'b0, pe = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 1) po ^= b[i];
      else            pe ^= b[i];
    end
    return {po, pe};
  endfunction

  function automatic logic pick(input logic f, input logic a, input logic h, input logic s);
    return f | (~f & ((a & h) | (~a & s)));
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rand_ctrl();
    rx_defect   = 1'($urandom);
    rx_bip_errs = ($urandom % 3 == 0) ? '0 : ERR_W'($urandom);
    rdi_auto_en = 1'($urandom);
    rdi_force   = ($urandom % 4 == 0);
    rdi_sw      = 1'($urandom);
    rei_auto_en = 1'($urandom);
    rei_force   = ($urandom % 4 == 0);
    rei_sw      = 1'($urandom);
    bip_inv     = ($urandom % 4 == 0);
    rfi_in      = 1'($urandom);
    label_in    = 3'($urandom);
    erdi_sw     = 3'($urandom);
  endtask

  // drive one cycle at the falling edge, check results at the next falling edge
  task automatic drive(input logic v, input logic mf, input logic [7:0] b);
    logic [7:0] exp_b;
    logic rdi_e, rei_e;
    logic [1:0] bip_e;
    in_valid = v; in_mf_start = mf; in_byte = b;
    exp_b = b;
    if (v && mf) begin
      rdi_e = pick(rdi_force, rdi_auto_en, rx_defect, rdi_sw);
      rei_e = pick(rei_force, rei_auto_en, rx_bip_errs != 0, rei_sw);
      bip_e = m_acc ^ (bip_inv ? 2'b11 : 2'b00);
      m_v5  = {bip_e, rei_e, rfi_in, label_in, rdi_e};
      m_k4  = rdi_force ? 3'b111 : erdi_sw;
      m_acc = par_of(m_v5);
      exp_b = m_v5;
    end else if (v) begin
      m_acc = m_acc ^ par_of(b);
    end
    @(negedge clk);
    if (!v) begin
      chk("R2 idle out_valid", {7'b0, out_valid}, 8'h00);
    end else if (mf) begin
      chk("R3 marker out_mf_start", {7'b0, out_mf_start}, 8'h01);
      chk("R3 V5 on stream", out_byte, exp_b);
      chk("R3 RFI/label", {4'b0, v5_last[4:1]}, {4'b0, m_v5[4:1]});
      chk(bip_inv ? "R12 inverted BIP-2" : "R4 BIP-2", {6'b0, v5_last[7:6]}, {6'b0, m_v5[7:6]});
      chk(rdi_force ? "R7 forced RDI" : (rdi_auto_en ? "R5 auto RDI" : "R6 manual RDI"),
          {7'b0, v5_last[0]}, {7'b0, m_v5[0]});
      chk(rei_force ? "R11 forced REI" : (rei_auto_en ? "R9 auto REI" : "R10 manual REI"),
          {7'b0, v5_last[5]}, {7'b0, m_v5[5]});
      chk(rdi_force ? "R7 K4 all ones" : "R8 K4 processor bits", {5'b0, k4_erdi}, {5'b0, m_k4});
    end else begin
      chk("R2 payload byte", out_byte, exp_b);
      chk("R2 payload flags", {6'b0, out_valid, out_mf_start}, 8'h02);
    end
    if (!(v && mf)) begin
      chk("R13 V5 held", v5_last, m_v5);
      chk("R13 K4 held", {5'b0, k4_erdi}, {5'b0, m_k4});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 0; in_mf_start = 0; in_byte = 0;
    rx_defect = 0; rx_bip_errs = '0; rdi_auto_en = 1; rdi_force = 0; rdi_sw = 0;
    rei_auto_en = 1; rei_force = 0; rei_sw = 0; bip_inv = 0; rfi_in = 0;
    label_in = 3'b000; erdi_sw = 3'b000;
    m_acc = 2'b00; m_v5 = 8'h00; m_k4 = 3'b000;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", {7'b0, out_valid}, 8'h00);
    chk("R1 reset v5_last", v5_last, 8'h00);
    chk("R1 reset k4_erdi", {5'b0, k4_erdi}, 8'h00);
    rst_n = 1'b1;

    // first multiframe after reset: parity must start from zero (R1)
    label_in = 3'b101;
    drive(1, 1, 8'hFF);
    chk("R1 first BIP-2 zero", {6'b0, v5_last[7:6]}, 8'h00);
    drive(1, 0, 8'h80);   // odd group only
    drive(1, 0, 8'h01);   // even group only
    drive(0, 0, 8'h00);
    drive(1, 0, 8'hAA);
    // R9: largest error count gives REI; R7: force with everything opposed
    rx_bip_errs = '1; rei_auto_en = 1; rdi_force = 1; rdi_auto_en = 1; rx_defect = 0;
    rdi_sw = 0; erdi_sw = 3'b000;
    drive(1, 1, 8'h00);
    drive(1, 0, 8'h55);
    // R9: zero count clears REI; R12 inversion on consecutive multiframes
    rx_bip_errs = '0; rdi_force = 0; bip_inv = 1;
    drive(1, 1, 8'h00);
    drive(1, 0, 8'h3C);
    drive(1, 1, 8'h00);
    bip_inv = 0;
    drive(1, 0, 8'hC3);

    // random multiframes with gaps and mid-multiframe control changes (R13)
    for (int mf = 0; mf < 400; mf++) begin
      int len;
      rand_ctrl();
      drive(1, 1, 8'($urandom));
      len = 3 + ($urandom % 18);
      for (int k = 0; k < len; k++) begin
        if ($urandom % 4 == 0) rand_ctrl();
        if ($urandom % 5 == 0) drive(0, 1'($urandom), 8'($urandom));
        else                   drive(1, 0, 8'($urandom));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule